// File: doc/BRIEF.md
# Half-Bit-Tick Serial Transmitter

This block sends asynchronous serial frames on a single line, timed by a free-running timebase. The timebase overflows once every half bit period, and the same tick is brought out so that a separate receiver can share it. A write places a data word in a one-deep holding register. The frame does not begin at the write. It begins on the next timebase tick, so the start can lag the write by up to half a bit. After that, the line moves only on every second tick until the frame is over.

The frame format is set by four configuration pins:
- an optional ninth data bit;
- an optional parity bit, even or odd, covering every data bit sent;
- one or two stop bits.

The holding register and the shift stage form a double buffer. Software can queue the next word while the current frame shifts out, and that word then follows with no idle gap. Two status outputs report an empty holding register and a fully completed transmission.

Top module: `uart_htx`

## Requirements
- R1: While and right after reset, `txd` is high, `tx_empty` is 1 and `tx_done` is 1.
- R2: `half_tick` is high for one clock in every `half_reload`+1 clocks. One serial bit lasts two ticks, which is 2*(`half_reload`+1) clocks.
- R3: An accepted write clears `tx_empty` and `tx_done` in the next cycle. The start bit appears on the clock edge that ends a `half_tick` cycle, at most `half_reload`+1 clocks after the write edge.
- R4: `txd` changes only on the edge that ends a `half_tick` cycle. Within a frame it changes only on every second tick, counted from the tick that started the frame.
- R5: The line idles high. A frame is a low start bit, then data bits 0 to 7 least significant first, then a high stop bit.
- R6: With `cfg_nine` = 1, `wr_data[8]` is sent directly after data bit 7.
- R7: With `cfg_par_en` = 1, a parity bit follows the last data bit. It is computed over data bits 0 to 7, plus bit 8 when `cfg_nine` = 1. For even parity (`cfg_par_odd` = 0) the bit makes the count of ones even; for odd parity it makes the count odd.
- R8: With `cfg_two_stop` = 1, the stop level lasts two bit times, and a queued frame starts two bit times after the last data or parity bit ends.
- R9: The held word moves into the shifter on the start edge of its frame, and `tx_empty` is 1 from that edge. A word written during a frame starts exactly at the end of that frame's last stop bit.
- R10: A write while `tx_empty` is 0 is ignored, and the word already held is the one sent.
- R11: `tx_done` goes to 1 on the edge that ends the last stop bit, and only if no word is waiting. In a back-to-back sequence it stays 0 between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_reload | input | RELOAD_W | Timebase reload; tick period is this value plus 1 clocks |
| cfg_nine | input | 1 | Send a ninth data bit |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| cfg_two_stop | input | 1 | Two stop bits instead of one |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send; bit 8 is used only with cfg_nine |
| half_tick | output | 1 | Half-bit timebase tick, shared with a receiver |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Holding register is free |
| tx_done | output | 1 | Line idle with nothing queued |

## Verification
The hardest case is the hand-over at the end of a frame, where the queued word must start on the same tick that ends the previous stop bit. That tick must neither shorten the stop bit nor insert an idle bit. The bench waits for `tx_empty` to rise at a start edge and only then writes the second word, so the word is held while the first frame is still shifting. It then measures the clocks between the two start edges, which must be exactly one frame length. Rejected writes are reached by writing on the cycle of a tick. The first word then stays held for a whole tick period, and the second write lands on a full register.

// File: rtl/uart_htx_pkg.sv
package uart_htx_pkg;

    localparam int unsigned DATA_MAX = 9;
    localparam int unsigned TAIL_MAX = DATA_MAX + 1 + 2;
    localparam int unsigned CNT_W    = $clog2(TAIL_MAX + 1);

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_t;

    function automatic logic calc_parity(input logic [DATA_MAX-1:0] d, input frame_cfg_t c);
        logic ones;
        ones = (^d[7:0]) ^ (c.nine & d[8]);
        return ones ^ c.par_odd;
    endfunction

    // Bits that follow the start bit, LSB first, padded with stop level.
    function automatic logic [TAIL_MAX-1:0] build_tail(input logic [DATA_MAX-1:0] d, input frame_cfg_t c);
        logic [TAIL_MAX-1:0] v;
        int idx;
        v      = '1;
        v[7:0] = d[7:0];
        idx    = 8;
        if (c.nine) begin
            v[8] = d[8];
            idx  = 9;
        end
        if (c.par_en) begin
            v[idx] = calc_parity(d, c);
        end
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] tail_len(input frame_cfg_t c);
        int n;
        n = 9;
        if (c.nine)     n = n + 1;
        if (c.par_en)   n = n + 1;
        if (c.two_stop) n = n + 1;
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/htx_timebase.sv
module htx_timebase #(
    parameter int unsigned RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);
    logic [RELOAD_W-1:0] cnt_q;

    assign tick = (cnt_q >= reload);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/htx_holding.sv
module htx_holding
    import uart_htx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                take,
    output logic                full,
    output logic [DATA_MAX-1:0] data
);
    logic                accept;
    logic                full_q;
    logic [DATA_MAX-1:0] data_q;

    assign accept = wr_en & ~full_q;
    assign full   = full_q;
    assign data   = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (take) begin
                full_q <= 1'b0;
            end
            if (accept) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/htx_shifter.sv
module htx_shifter
    import uart_htx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  frame_cfg_t          cfg,
    input  logic                hold_full,
    input  logic [DATA_MAX-1:0] hold_data,
    output logic                take,
    output logic                txd,
    output logic                busy,
    output logic                done
);
    sh_state_t           state_q;
    logic                skip_q;
    logic [TAIL_MAX-1:0] tail_q;
    logic [CNT_W-1:0]    left_q;
    logic                txd_q;
    logic                done_q;
    logic                active_tick;
    logic                frame_end;
    logic                start;

    assign active_tick = tick & (state_q == SH_RUN) & ~skip_q;
    assign frame_end   = active_tick & (left_q == '0);
    assign start       = tick & hold_full & ((state_q == SH_IDLE) | frame_end);

    assign take = start;
    assign txd  = txd_q;
    assign busy = (state_q == SH_RUN);
    assign done = done_q & ~hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            skip_q  <= 1'b0;
            tail_q  <= '1;
            left_q  <= '0;
            txd_q   <= 1'b1;
            done_q  <= 1'b1;
        end else if (start) begin
            state_q <= SH_RUN;
            skip_q  <= 1'b1;
            tail_q  <= build_tail(hold_data, cfg);
            left_q  <= tail_len(cfg);
            txd_q   <= 1'b0;
            done_q  <= 1'b0;
        end else if (frame_end) begin
            state_q <= SH_IDLE;
            skip_q  <= 1'b0;
            txd_q   <= 1'b1;
            done_q  <= 1'b1;
        end else if (tick && state_q == SH_RUN) begin
            if (skip_q) begin
                skip_q <= 1'b0;
            end else begin
                txd_q  <= tail_q[0];
                tail_q <= {1'b1, tail_q[TAIL_MAX-1:1]};
                left_q <= left_q - 1'b1;
                skip_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_htx.sv
module uart_htx
    import uart_htx_pkg::*;
#(
    parameter int unsigned RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RELOAD_W-1:0] half_reload,
    input  logic                cfg_nine,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                wr_en,
    input  logic [8:0]          wr_data,
    output logic                half_tick,
    output logic                txd,
    output logic                tx_empty,
    output logic                tx_done
);
    frame_cfg_t          cfg;
    logic                hold_full;
    logic [DATA_MAX-1:0] hold_data;
    logic                sh_take;
    logic                sh_busy;

    assign cfg = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};
    assign tx_empty = ~hold_full;

    htx_timebase #(.RELOAD_W(RELOAD_W)) i_tb (
        .clk    (clk),
        .rst    (rst),
        .reload (half_reload),
        .tick   (half_tick)
    );

    htx_holding i_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (sh_take),
        .full    (hold_full),
        .data    (hold_data)
    );

    htx_shifter i_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (half_tick),
        .cfg       (cfg),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (sh_take),
        .txd       (txd),
        .busy      (sh_busy),
        .done      (tx_done)
    );
endmodule

// File: rtl/htx_checker.sv
module htx_checker (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic half_tick,
    input logic tx_empty,
    input logic tx_done,
    input logic wr_en,
    input logic busy
);
    p_start_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(half_tick));

    p_write_fills_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tx_empty) |=> !tx_empty);

    p_line_steady_r4: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> $stable(txd));

    p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    p_done_line_idle_r11: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (txd && !busy));

    p_done_empty_r11: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> tx_empty);
endmodule

bind uart_htx htx_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .txd       (txd),
    .half_tick (half_tick),
    .tx_empty  (tx_empty),
    .tx_done   (tx_done),
    .wr_en     (wr_en),
    .busy      (sh_busy)
);

// File: tb/test_uart_htx.sv
module test_uart_htx;
    localparam int RL  = 3;
    localparam int BIT = 2 * (RL + 1);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [15:0] half_reload = 16'(RL);
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       half_tick, txd, tx_empty, tx_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int nbits = 10;
    int n_cap = 0;
    logic [15:0] cap_bits [0:15];
    int cap_t [0:15];
    logic cap_tk [0:15];
    int done_t = 0;
    int viol = 0;
    logic pd = 1'b1, ptx = 1'b1, ptick = 1'b0;
    bit ended = 0;

    always #2 clk = ~clk;

    uart_htx i_uart_htx (
        .clk(clk), .rst(rst), .half_reload(half_reload),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .wr_en(wr_en), .wr_data(wr_data),
        .half_tick(half_tick), .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && tx_done && !pd) done_t = cyc;
        if (!rst && (txd != ptx) && !ptick) viol = viol + 1;
        pd = tx_done;
        ptx = txd;
        ptick = half_tick;
    end

    // frame decoder: samples each bit at its centre
    initial begin : mon
        logic pt, ptk;
        logic [15:0] b;
        int k;
        pt = 1'b1;
        ptk = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && pt && !txd) begin
                k = n_cap;
                b = '1;
                cap_t[k] = cyc;
                cap_tk[k] = ptk;
                for (int i = 0; i < nbits; i++) begin
                    repeat ((i == 0) ? BIT / 2 : BIT) @(negedge clk);
                    b[i] = txd;
                end
                cap_bits[k] = b;
                n_cap = k + 1;
            end
            pt = txd;
            ptk = half_tick;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_frame(input logic [8:0] d, input logic nine, input logic pe,
                                     input logic po, input logic ts, output logic [15:0] e);
        int idx;
        logic p;
        e = '1;
        e[0] = 1'b0;
        idx = 1;
        for (int i = 0; i < 8; i++) begin
            e[idx] = d[i];
            idx++;
        end
        if (nine) begin
            e[idx] = d[8];
            idx++;
        end
        if (pe) begin
            p = (^d[7:0]) ^ (nine & d[8]);
            if (po) p = ~p;
            e[idx] = p;
            idx++;
        end
        idx = idx + 1 + (ts ? 1 : 0);
        return idx;
    endfunction

    task automatic setup(input logic nine, input logic pe, input logic po, input logic ts);
        logic [15:0] dummy;
        cfg_nine = nine;
        cfg_par_en = pe;
        cfg_par_odd = po;
        cfg_two_stop = ts;
        nbits = exp_frame(9'h0, nine, pe, po, ts, dummy);
        n_cap = 0;
    endtask

    task automatic write_word(input logic [8:0] d, output int t_edge);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        t_edge = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_caps(input int n);
        int guard;
        guard = 0;
        while (n_cap < n && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (!tx_done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_and_check(input string req, input logic [8:0] d);
        logic [15:0] e;
        int n, tw;
        n = exp_frame(d, cfg_nine, cfg_par_en, cfg_par_odd, cfg_two_stop, e);
        n_cap = 0;
        write_word(d, tw);
        wait_caps(1);
        check({req, " frame bits"}, 32'(cap_bits[0] & ((16'h1 << n) - 1)), 32'(e & ((16'h1 << n) - 1)));
        wait_idle();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 txd in reset", 32'(txd), 1);
        check("R1 tx_empty in reset", 32'(tx_empty), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 txd after reset", 32'(txd), 1);
        check("R1 tx_done after reset", 32'(tx_done), 1);
    endtask

    task automatic t_tick_period();
        int c1, c2, width;
        while (!half_tick) @(negedge clk);
        c1 = cyc;
        @(negedge clk);
        width = 0;
        while (!half_tick) begin
            @(negedge clk);
            width++;
        end
        c2 = cyc;
        check("R2 tick period", 32'(c2 - c1), 32'(RL + 1));
        check("R2 tick low span", 32'(width), 32'(RL));
    endtask

    task automatic t_basic();
        logic [15:0] e;
        int n, tw;
        setup(0, 0, 0, 0);
        n = exp_frame(9'h0A5, 0, 0, 0, 0, e);
        write_word(9'h0A5, tw);
        check("R3 tx_empty cleared after write", 32'(tx_empty), 0);
        check("R3 tx_done cleared after write", 32'(tx_done), 0);
        wait_caps(1);
        check("R5 frame 0xA5 8N1", 32'(cap_bits[0] & 16'h03FF), 32'(e & 16'h03FF));
        check("R3 start follows tick", 32'(cap_tk[0]), 1);
        check("R3 latency within half bit", 32'((cap_t[0] - tw) >= 1 && (cap_t[0] - tw) <= RL + 1), 1);
        wait_idle();
        check("R11 done at end of stop", 32'(done_t - cap_t[0]), 32'(n * BIT));
        send_and_check("R5 pattern 0x3C", 9'h03C);
        send_and_check("R5 pattern 0x00", 9'h000);
        send_and_check("R5 pattern 0xFF", 9'h0FF);
        check("R4 line moved only after ticks", 32'(viol), 0);
    endtask

    task automatic t_ninth();
        setup(1, 0, 0, 0);
        send_and_check("R6 ninth bit one", 9'h13C);
        send_and_check("R6 ninth bit zero", 9'h0C3);
    endtask

    task automatic t_parity();
        setup(0, 1, 0, 0);
        send_and_check("R7 even parity 0x07", 9'h007);
        setup(0, 1, 1, 0);
        send_and_check("R7 odd parity 0x07", 9'h007);
        setup(1, 1, 0, 0);
        send_and_check("R7 even parity with ninth", 9'h101);
        setup(1, 1, 1, 1);
        send_and_check("R7 odd parity nine two stop", 9'h1F0);
    endtask

    task automatic t_chain(input string req, input logic ts);
        logic [15:0] ea, eb;
        int n, tw, guard;
        setup(0, 0, 0, ts);
        n = exp_frame(9'h05A, 0, 0, 0, ts, ea);
        n = exp_frame(9'h0C6, 0, 0, 0, ts, eb);
        write_word(9'h05A, tw);
        guard = 0;
        while (!tx_empty && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check({req, " empty at start edge"}, 32'(txd), 0);
        write_word(9'h0C6, tw);
        wait_caps(2);
        check({req, " first frame"}, 32'(cap_bits[0]), 32'(ea | ~((16'h1 << n) - 1)) & 32'(cap_bits[0] | ((16'h1 << n) - 1)) );
        check({req, " second frame"}, 32'(cap_bits[1] & ((16'h1 << n) - 1)), 32'(eb & ((16'h1 << n) - 1)));
        check({req, " spacing"}, 32'(cap_t[1] - cap_t[0]), 32'(n * BIT));
        wait_idle();
        check("R11 done stays low between frames", 32'(done_t - cap_t[1]), 32'(n * BIT));
    endtask

    task automatic t_ignored();
        logic [15:0] e;
        int n, tw;
        setup(0, 0, 0, 0);
        n = exp_frame(9'h081, 0, 0, 0, 0, e);
        while (!half_tick) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 9'h081;
        @(negedge clk);
        check("R10 holding full before second write", 32'(tx_empty), 0);
        wr_data = 9'h07E;
        @(negedge clk);
        wr_en = 1'b0;
        wait_caps(1);
        check("R10 held word sent", 32'(cap_bits[0] & 16'h03FF), 32'(e & 16'h03FF));
        wait_idle();
        repeat (12 * BIT) @(negedge clk);
        check("R10 rejected word never sent", 32'(n_cap), 1);
        check("R11 done while idle", 32'(tx_done), 1);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_tick_period();
                t_basic();
                t_ninth();
                t_parity();
                t_chain("R9 back to back", 1'b0);
                t_chain("R8 two stop chain", 1'b1);
                t_ignored();
                check("R4 no off-tick line change", 32'(viol), 0);
            end
            begin
                repeat (150000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        finish_run();
    end
endmodule